// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is a serial peripheral master that a processor controls through a small word-addressed register interface. Software picks the serial clock rate and the clock polarity and phase through one control byte. It enables master operation, then writes a byte to the transmit register. That write starts a full-duplex exchange of exactly eight bits, most significant bit first. The block drives an active-low chip select around the byte. The byte shifted in from the slave lands in the receive register, and a status flag marks it as ready.

The serial clock comes from a two-stage divider. A prescaler select picks a base divide of 16 or 128. A five-bit count N then stretches each serial clock half period to N+1 prescaled units. Software waits for the busy flag to clear before it writes the next byte. It collects the received byte by reading the receive register, and that read also clears the ready flag.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, every register reads zero, the chip select is high (inactive) and the serial clock is low.
- R2: The control register at offset 0x00 holds CPHA in bit 7, CPOL in bit 6, the prescaler select in bit 5 and N in bits 4:0. A write to it while an exchange is in progress is ignored.
- R3: One serial clock half period lasts P*(N+1) system clock cycles, with P=16 when bit 5 is 0 and P=128 when bit 5 is 1. When no exchange is running, the serial clock sits at the CPOL level. An exchange produces exactly 16 serial clock edges.
- R4: The chip select goes low in the cycle after a transfer starts. It stays low for exactly 17 half periods: one half period before the first edge, 16 edges one half period apart, and one half period after the last edge.
- R5: Bit 0 of the mode register at offset 0x08 enables master operation. A write to the transmit register while that bit is 0 starts nothing.
- R6: A write to the transmit register at offset 0x0C starts an exchange of the low 8 bits of the written data. Status bit 0 reads 1 from the cycle after that write until the exchange ends. A transmit write while an exchange is running is ignored. The transmit register reads as zero.
- R7: Data moves most significant bit first. With CPHA=0, MOSI holds the first bit before the first edge, MISO is sampled on leading edges and MOSI changes on trailing edges. With CPHA=1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R8: At the end of an exchange, the received byte appears in bits 7:0 of the receive register at offset 0x10, and status bit 2 (receive full) goes to 1. A read of the receive register clears status bit 2.
- R9: A write to the status register at offset 0x04 with bit 2 equal to 0 clears the receive-full flag. A write with bit 2 equal to 1 leaves the flag unchanged.
- R10: The secondary control register at offset 0x14 stores and returns 8 bits and has no effect on the serial interface.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears receive full when the receive register is read) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Checks run on every cycle and cover the control byte staying frozen during an exchange, the edge count never passing sixteen, and the serial clock ending each exchange back at its CPOL level. They also check that the receive-full flag is set when busy falls and that a transfer only starts with master mode enabled. Other behaviour only shows up in the bench's scenarios: the exact half-period timing for each divider setting, the chip select framing, the bit order and sampling edge in all four clock modes, and the byte that reaches the receive register. The same goes for the ignored writes and the flag-clearing paths. A behavioural slave and a cycle model observe these at the pins.

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master #(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 128,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          spi_sck,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          spi_cs_n
);
  localparam int CW = $clog2(DIV_HI * 32) + 1;
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_STAT = AW'(8'h04);
  localparam logic [AW-1:0] A_MODE = AW'(8'h08);
  localparam logic [AW-1:0] A_TX   = AW'(8'h0C);
  localparam logic [AW-1:0] A_RX   = AW'(8'h10);
  localparam logic [AW-1:0] A_AUX  = AW'(8'h14);

  logic [7:0]    ctrl, aux, rx_data, tx_sh, rx_sh;
  logic          master, busy, rx_full, sck_q;
  logic [CW-1:0] hcnt;
  logic [4:0]    ecnt;

  wire           cpha    = ctrl[7];
  wire           cpol    = ctrl[6];
  wire [CW-1:0]  half_len = (ctrl[5] ? CW'(DIV_HI) : CW'(DIV_LO)) * (CW'(ctrl[4:0]) + CW'(1));
  wire           half_end = hcnt == half_len - CW'(1);
  wire           leading  = ~ecnt[0];
  wire           launch   = bus_wr && bus_addr == A_TX && master && !busy;
  wire           do_sample = leading ^ cpha;
  wire           do_shift  = cpha ? (leading && ecnt != 5'd0) : !leading;

  assign spi_sck  = busy ? sck_q : cpol;
  assign spi_mosi = tx_sh[7];
  assign spi_cs_n = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; aux <= '0; rx_data <= '0; tx_sh <= '0; rx_sh <= '0;
      master <= 1'b0; busy <= 1'b0; rx_full <= 1'b0; sck_q <= 1'b0;
      hcnt <= '0; ecnt <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL && !busy) ctrl <= bus_wdata[7:0];
      if (bus_wr && bus_addr == A_MODE) master <= bus_wdata[0];
      if (bus_wr && bus_addr == A_AUX) aux <= bus_wdata[7:0];
      if ((bus_wr && bus_addr == A_STAT && !bus_wdata[2]) || (bus_rd && bus_addr == A_RX))
        rx_full <= 1'b0;
      if (launch) begin
        busy  <= 1'b1;
        hcnt  <= '0;
        ecnt  <= '0;
        tx_sh <= bus_wdata[7:0];
        sck_q <= cpol;
      end else if (busy) begin
        if (half_end) begin
          hcnt <= '0;
          if (ecnt != 5'd16) begin
            sck_q <= ~sck_q;
            ecnt  <= ecnt + 5'd1;
            if (do_sample) rx_sh <= {rx_sh[6:0], spi_miso};
            if (do_shift)  tx_sh <= {tx_sh[6:0], 1'b0};
          end else begin
            busy    <= 1'b0;
            rx_data <= rx_sh;
            rx_full <= 1'b1;
          end
        end else begin
          hcnt <= hcnt + CW'(1);
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {24'd0, ctrl};
      A_STAT:  bus_rdata = {29'd0, rx_full, 1'b0, busy};
      A_MODE:  bus_rdata = {31'd0, master};
      A_RX:    bus_rdata = {24'd0, rx_data};
      A_AUX:   bus_rdata = {24'd0, aux};
      default: bus_rdata = '0;
    endcase
  end

  a_r2_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctrl));
  a_r3_sck_home: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sck_q == ctrl[6]);
  a_r4_edge_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= 5'd16);
  a_r5_master_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> master);
  a_r8_full_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rx_full);
endmodule

// File: tb/spi_byte_master_bench.sv
`timescale 1ns/1ps
module spi_byte_master_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  spi_byte_master u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  int checks = 0, errors = 0;
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural cycle model
  logic [7:0] m_ctrl = 0, m_aux = 0, m_rx = 0, m_tx = 0, m_slave_cur = 0, slave_byte = 0;
  bit m_master = 0, m_busy = 0, m_full = 0, old = 0, cpol_l = 0, cpha_l = 0;
  int k = 0, H = 16;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_aux = 0; m_rx = 0; m_master = 0; m_busy = 0; m_full = 0; k = 0;
    end else begin
      old = m_busy;
      if (bus_rd && bus_addr == 5'h10) m_full = 0;
      if (bus_wr && bus_addr == 5'h04 && !bus_wdata[2]) m_full = 0;
      if (old) begin
        k++;
        if (k == 17 * H) begin m_busy = 0; m_full = 1; m_rx = m_slave_cur; end
      end
      if (bus_wr) begin
        case (bus_addr)
          5'h00: if (!old) m_ctrl = bus_wdata[7:0];
          5'h08: m_master = bus_wdata[0];
          5'h14: m_aux = bus_wdata[7:0];
          5'h0C: if (m_master && !old) begin
            m_busy = 1; k = 0;
            H = (m_ctrl[5] ? 128 : 16) * (int'(m_ctrl[4:0]) + 1);
            cpol_l = m_ctrl[6]; cpha_l = m_ctrl[7];
            m_tx = bus_wdata[7:0]; m_slave_cur = slave_byte;
          end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_read(logic [4:0] a);
    case (a)
      5'h00: return {24'd0, m_ctrl};
      5'h04: return {29'd0, m_full, 1'b0, m_busy};
      5'h08: return {31'd0, m_master};
      5'h10: return {24'd0, m_rx};
      5'h14: return {24'd0, m_aux};
      default: return 32'd0;
    endcase
  endfunction

  // per-cycle pin comparison and behavioural slave
  logic prev_sck = 0, prev_cs = 1;
  logic [7:0] sl_rx = 0;
  int sl_edges = 0, sl_pos = 7, lowcnt = 0, edges;
  bit lead;
  always @(negedge clk) begin
    if (rst_n) begin
      edges = (k / H > 16) ? 16 : k / H;
      chk("R3 sck level", spi_sck, m_busy ? (cpol_l ^ edges[0]) : m_ctrl[6]);
      chk("R4 chip select", spi_cs_n, !m_busy);
      if (!spi_cs_n) lowcnt++;
      if (prev_cs && !spi_cs_n) begin
        sl_edges = 0; sl_pos = 7; sl_rx = 0;
        if (!cpha_l) begin spi_miso = m_slave_cur[7]; sl_pos = 6; end
      end else if (!spi_cs_n && spi_sck !== prev_sck) begin
        lead = (sl_edges % 2 == 0);
        sl_edges++;
        if (lead ^ cpha_l) sl_rx = {sl_rx[6:0], spi_mosi};
        else if (sl_pos >= 0) begin spi_miso = m_slave_cur[sl_pos]; sl_pos--; end
      end
      if (!prev_cs && spi_cs_n) begin
        chk("R7 byte seen by slave", sl_rx, m_tx);
        chk("R3 edge count", sl_edges, 16);
        chk("R4 frame length", lowcnt, 17 * H);
        lowcnt = 0;
      end
      prev_sck = spi_sck; prev_cs = spi_cs_n;
    end
  end

  logic [31:0] last;
  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic rd(string req, logic [4:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 last = bus_rdata; chk(req, last, exp_read(a));
    @(negedge clk); bus_rd = 1'b0;
  endtask
  task automatic wait_idle();
    do rd("R6 busy poll", 5'h04); while (last[0]);
  endtask
  task automatic xfer(logic [7:0] ctl, logic [7:0] txb, logic [7:0] slv);
    wr(5'h00, {24'd0, ctl});
    slave_byte = slv;
    wr(5'h0C, {24'hABCDEF, txb});
    wait_idle();
    rd("R8 full set", 5'h04);
    rd("R8 rx byte", 5'h10);
    rd("R8 full cleared by read", 5'h04);
  endtask

  initial begin
    #200000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    for (int a = 0; a < 6; a++) rd("R1 reset reg", 5'(a * 4));
    chk("R1 cs_n idle", spi_cs_n, 1'b1);
    chk("R1 sck idle", spi_sck, 1'b0);
    // R5 no launch without master mode
    wr(5'h0C, 32'h5A);
    repeat (40) @(negedge clk);
    rd("R5 no start when not master", 5'h04);
    wr(5'h08, 32'h1);
    rd("R5 mode readback", 5'h08);
    // R7 all four clock modes
    for (int m = 0; m < 4; m++) xfer({m[0], m[1], 6'd0}, 8'hA5 ^ 8'(m * 37), 8'h3C + 8'(m * 19));
    // R3 divider variants
    xfer(8'h02, 8'h81, 8'h7E);
    xfer(8'h60, 8'h0F, 8'hF0);
    // R9 status write clears
    wr(5'h00, 32'h0); slave_byte = 8'h55;
    wr(5'h0C, 32'hC3); wait_idle();
    wr(5'h04, 32'h4);
    rd("R9 bit2 set keeps flag", 5'h04);
    wr(5'h04, 32'h0);
    rd("R9 write zero clears", 5'h04);
    rd("R8 rx byte", 5'h10);
    // R6/R2 writes ignored during exchange
    slave_byte = 8'h99;
    wr(5'h0C, 32'h12);
    repeat (30) @(negedge clk);
    wr(5'h0C, 32'hED);
    wr(5'h00, 32'hE5);
    rd("R2 ctrl frozen while busy", 5'h00);
    rd("R6 transmit reads zero", 5'h0C);
    wait_idle();
    rd("R8 rx byte", 5'h10);
    // R10 secondary register
    wr(5'h14, 32'h5A);
    rd("R10 aux readback", 5'h14);
    rd("R10 no start", 5'h04);
    chk("R10 cs idle", spi_cs_n, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule